// File: doc/BRIEF.md
# Boundary-Scan Test Port with Pin Wrapper

This block places serial test logic around a small device that has a handful of input and output pins. An external tester drives a test clock, a mode-select line and serial data in. It reads serial data back on a test output that is enabled only while bits are being shifted. A sixteen-state controller, stepped by the mode-select line alone, walks the tester through instruction and data scans. The 2-bit instruction chooses which of three data registers sits between serial in and serial out: a one-bit bypass stage, a 32-bit identification word, or a boundary register with one cell per functional pin.

Each boundary cell has a capture/shift stage and an update hold stage. The capture/shift stage either takes the cell's parallel input or shifts from its neighbour. The hold stage is loaded at the end of a data scan. A mode select on each output cell puts either the core's value or the held test value onto the pin. This lets the tester observe the pins without disturbing them, load test values in advance, and then drive and sense the board wiring from the wrapper. The test pins themselves carry no boundary cells.

After any reset the identification instruction is active. A tester that knows nothing about the board can therefore scan the data chain and see a leading 1 for this device.

Top module: `scan_port_dev`

## Requirements
- R1: The controller has sixteen states and moves between them only on rising `tck` edges, driven by `tms`. Five rising edges with `tms` high reach Test-Logic-Reset from any state. Driving `trst_n` low forces Test-Logic-Reset at once. The Pause-DR and Exit2-DR loop resumes shifting without losing bits.
- R2: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high exactly when the controller is in Shift-IR or Shift-DR. `tdo` then carries bit 0 of the register being shifted.
- R3: The instruction register is 2 bits. It captures 01 and shifts in from `tdi` with bit 0 leaving first. The new instruction takes effect on leaving Update-IR. The codes are 00 drive-pins (EXTEST), 01 sample/preload, 10 identify, 11 bypass.
- R4: After `trst_n` or Test-Logic-Reset, the active instruction is identify. The first bit of a data scan is therefore 1.
- R5: The identify register captures {version[3:0], part[15:0], maker[10:0], 1'b1} from MSB to LSB and shifts out LSB first.
- R6: Under bypass, the data path is one stage that captures 0. Each scanned-out bit is therefore the `tdi` bit from one shift earlier, preceded by a 0.
- R7: Under sample/preload, a data scan captures {core_out, pin_in}. Boundary bits 0..N_IN-1 are `pin_in`, and the bits above them are `core_out`; bit 0 is scanned out first. Meanwhile `pin_out` follows `core_out` and `core_in` follows `pin_in` throughout.
- R8: The bits shifted into the boundary register are copied into the hold stages on leaving Update-DR under either sample/preload or drive-pins. A later drive-pins instruction uses values preloaded this way.
- R9: Under drive-pins, `pin_out` shows the held bits N_IN and above, and ignores `core_out`. A data scan still captures {core_out, pin_in}. `core_in` keeps following `pin_in`.
- R10: Hold stages do not change during Capture-DR, Shift-DR or Pause-DR, so `pin_out` stays steady under drive-pins until Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, steps the controller |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling edge |
| tdo_oe | output | 1 | High while `tdo` is driven (shift states) |
| pin_in | input | N_IN | Device input pins |
| core_in | output | N_IN | Input pin values passed to the core |
| core_out | input | N_OUT | Core values bound for output pins |
| pin_out | output | N_OUT | Device output pins |

## Verification
The bound checker watches a fixed set of properties on every rising edge. Test-Logic-Reset holds while `tms` stays high and always restores the identify instruction. The instruction capture value is 01. The output enable tracks the shift states. The pins follow the core whenever drive-pins is not active. Held pin values stay steady while data is shifted. Whole-scan results cannot be checked edge by edge: the identification word, the bypass delay, the boundary capture order, preload followed by drive-pins, a scan broken by a pause, and recovery through five `tms` ones and through `trst_n`. The bench's reference model checks these, comparing the ports on every falling edge.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_t;

  localparam int IR_W = 2;
  localparam int ID_W = 32;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 2'b00,
    OP_SAMPLE = 2'b01,
    OP_IDCODE = 2'b10,
    OP_BYPASS = 2'b11
  } op_t;

  localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

  // One controller step for a given mode-select value.
  function automatic tap_state_t tap_step(tap_state_t s, logic m);
    case (s)
      TS_RESET:    return m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     return m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   return m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   return m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: return m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: return m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: return m ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: return m ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   return m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   return m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   return m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: return m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: return m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: return m ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: return m ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   return m ? TS_SEL_DR   : TS_IDLE;
      default:     return TS_RESET;
    endcase
  endfunction

  // Identification word: version, part, maker, then a constant 1 in bit 0.
  function automatic logic [ID_W-1:0] id_word(logic [3:0] v, logic [15:0] p, logic [10:0] mk);
    return {v, p, mk, 1'b1};
  endfunction

endpackage

// File: rtl/scan_port_tap.sv
module scan_port_tap
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state,
  output logic       in_reset,
  output logic       cap_dr,
  output logic       sh_dr,
  output logic       up_dr,
  output logic       cap_ir,
  output logic       sh_ir,
  output logic       up_ir
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= tap_step(state, tms);
  end

  assign in_reset = (state == TS_RESET);
  assign cap_dr   = (state == TS_CAP_DR);
  assign sh_dr    = (state == TS_SHIFT_DR);
  assign up_dr    = (state == TS_UPD_DR);
  assign cap_ir   = (state == TS_CAP_IR);
  assign sh_ir    = (state == TS_SHIFT_IR);
  assign up_ir    = (state == TS_UPD_IR);

endmodule

// File: rtl/scan_port_cell.sv
module scan_port_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic si,
  input  logic pi,
  input  logic shift_en,
  input  logic clk_en,
  input  logic upd_en,
  input  logic mode,
  output logic so,
  output logic po
);

  logic cap_q;
  logic hold_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      cap_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (clk_en) cap_q  <= shift_en ? si : pi;
      if (upd_en) hold_q <= cap_q;
    end
  end

  assign so = cap_q;
  assign po = mode ? hold_q : pi;

endmodule

// File: rtl/scan_port_dev.sv
module scan_port_dev
  import scan_port_pkg::*;
#(
  parameter int          N_IN    = 2,
  parameter int          N_OUT   = 3,
  parameter logic [3:0]  ID_VER  = 4'h1,
  parameter logic [15:0] ID_PART = 16'h5AC3,
  parameter logic [10:0] ID_MFR  = 11'h0A5
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);

  localparam int             NB     = N_IN + N_OUT;
  localparam logic [ID_W-1:0] ID_VAL = id_word(ID_VER, ID_PART, ID_MFR);

  tap_state_t st;
  logic in_reset, cap_dr, sh_dr, up_dr, cap_ir, sh_ir, up_ir;

  scan_port_tap u_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(st),
    .in_reset(in_reset), .cap_dr(cap_dr), .sh_dr(sh_dr), .up_dr(up_dr),
    .cap_ir(cap_ir), .sh_ir(sh_ir), .up_ir(up_ir)
  );

  // Instruction path
  logic [IR_W-1:0] ir_sr;
  op_t             ir_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      if (cap_ir)     ir_sr <= IR_CAPTURE;
      else if (sh_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (in_reset)   ir_q  <= OP_IDCODE;
      else if (up_ir) ir_q  <= op_t'(ir_sr);
    end
  end

  // Data register selection
  logic sel_bsr, sel_id, sel_byp, extest;
  always_comb begin
    sel_bsr = 1'b0;
    sel_id  = 1'b0;
    sel_byp = 1'b0;
    case (ir_q)
      OP_EXTEST, OP_SAMPLE: sel_bsr = 1'b1;
      OP_IDCODE:            sel_id  = 1'b1;
      default:              sel_byp = 1'b1;
    endcase
  end
  assign extest = (ir_q == OP_EXTEST);

  // Bypass stage and identification register
  logic            byp_q;
  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sr <= '0;
    end else begin
      if (sel_byp && cap_dr)      byp_q <= 1'b0;
      else if (sel_byp && sh_dr)  byp_q <= tdi;
      if (sel_id && cap_dr)       id_sr <= ID_VAL;
      else if (sel_id && sh_dr)   id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  // Boundary register: bit 0 nearest tdo, inputs low, outputs high
  logic [NB:0]   link;
  logic [NB-1:0] cell_pi, cell_po, cell_mode;

  assign link[NB]  = tdi;
  assign cell_pi   = {core_out, pin_in};
  assign cell_mode = {{N_OUT{extest}}, {N_IN{1'b0}}};

  for (genvar i = 0; i < NB; i++) begin : g_cell
    scan_port_cell u_cell (
      .tck(tck), .trst_n(trst_n),
      .si(link[i+1]), .pi(cell_pi[i]),
      .shift_en(sh_dr), .clk_en(sel_bsr && (cap_dr || sh_dr)),
      .upd_en(sel_bsr && up_dr), .mode(cell_mode[i]),
      .so(link[i]), .po(cell_po[i])
    );
  end

  assign core_in = cell_po[N_IN-1:0];
  assign pin_out = cell_po[NB-1:N_IN];

  // Serial output, registered on the falling edge
  logic dr_so;
  always_comb begin
    if (sel_bsr)     dr_so = link[0];
    else if (sel_id) dr_so = id_sr[0];
    else             dr_so = byp_q;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= sh_ir ? ir_sr[0] : dr_so;
      tdo_oe <= sh_ir || sh_dr;
    end
  end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int N_OUT = 3
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tms,
  input tap_state_t       st,
  input op_t              ir_q,
  input logic [IR_W-1:0]  ir_sr,
  input logic             cap_ir,
  input logic             sh_dr,
  input logic             tdo_oe,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] pin_out
);

  a_r1_reset_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TS_RESET && tms) |=> (st == TS_RESET));

  a_r2_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (st == TS_SHIFT_DR || st == TS_SHIFT_IR));

  a_r3_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
    cap_ir |=> (ir_sr == IR_CAPTURE));

  a_r4_reset_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TS_RESET) |=> (ir_q == OP_IDCODE));

  a_r7_pins_follow: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q != OP_EXTEST) |-> (pin_out == core_out));

  a_r10_steady_shift: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == OP_EXTEST && sh_dr) |=> $stable(pin_out));

endmodule

bind scan_port_dev scan_port_chk #(.N_OUT(N_OUT)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_q(ir_q), .ir_sr(ir_sr),
  .cap_ir(cap_ir), .sh_dr(sh_dr), .tdo_oe(tdo_oe), .core_out(core_out), .pin_out(pin_out)
);

// File: tb/scan_port_dev_test.sv
module scan_port_dev_test;

  localparam int NI = 2;
  localparam int NO = 3;
  localparam int NB = NI + NO;
  localparam logic [3:0]  VER  = 4'h1;
  localparam logic [15:0] PART = 16'h5AC3;
  localparam logic [10:0] MFR  = 11'h0A5;
  localparam logic [31:0] ID_EXP = (32'(VER) << 28) | (32'(PART) << 12) | (32'(MFR) << 1) | 32'd1;

  // instruction codes from R3
  localparam logic [1:0] C_DRIVE = 2'b00, C_SAMPLE = 2'b01, C_ID = 2'b10, C_BYP = 2'b11;

  // controller states, own numbering
  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PSD = 6, E2D = 7, UPD = 8;
  localparam int SIR = 9, CIR = 10, SHI = 11, E1I = 12, PSI = 13, E2I = 14, UPI = 15;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0;
  logic tdo, tdo_oe;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pin_out;

  scan_port_dev #(.N_IN(NI), .N_OUT(NO), .ID_VER(VER), .ID_PART(PART), .ID_MFR(MFR)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
  );

  always #4 tck = ~tck;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model
  int ms;
  logic [1:0] mir, mirs;
  logic mbyp, seen_tdo;
  logic [31:0] mid;
  logic [NB-1:0] mbsr, mhold;

  function automatic int nxt(int s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;
      E1D: return m ? UPD : PSD;
      PSD: return m ? E2D : PSD;
      E2D: return m ? UPD : SHD;
      UPD: return m ? SDR : RTI;
      SIR: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;
      SHI: return m ? E1I : SHI;
      E1I: return m ? UPI : PSI;
      PSI: return m ? E2I : PSI;
      E2I: return m ? UPI : SHI;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  task automatic model_reset();
    ms = TLR; mir = C_ID; mirs = 2'b01; mbyp = 0; mid = 0; mbsr = '0; mhold = '0;
  endtask

  task automatic model_rise();
    bit bs;
    bs = (mir == C_DRIVE) || (mir == C_SAMPLE);
    case (ms)
      TLR: mir = C_ID;
      CIR: mirs = 2'b01;
      SHI: mirs = {tdi, mirs[1]};
      UPI: mir = mirs;
      CDR: begin
        if (bs) mbsr = {core_out, pin_in};
        else if (mir == C_ID) mid = ID_EXP;
        else mbyp = 1'b0;
      end
      SHD: begin
        if (bs) mbsr = {tdi, mbsr[NB-1:1]};
        else if (mir == C_ID) mid = {tdi, mid[31:1]};
        else mbyp = tdi;
      end
      UPD: if (bs) mhold = mbsr;
      default: ;
    endcase
    ms = nxt(ms, tms);
  endtask

  task automatic compare_ports();
    logic eoe, etdo;
    eoe = (ms == SHD) || (ms == SHI);
    if (ms == SHI) etdo = mirs[0];
    else if (mir == C_DRIVE || mir == C_SAMPLE) etdo = mbsr[0];
    else if (mir == C_ID) etdo = mid[0];
    else etdo = mbyp;
    check("R2 tdo_oe", 32'(tdo_oe), 32'(eoe));
    if (eoe) check("R2 tdo", 32'(tdo), 32'(etdo));
    check("R9 pin_out", 32'(pin_out), (mir == C_DRIVE) ? 32'(mhold[NB-1:NI]) : 32'(core_out));
    check("R7 core_in", 32'(core_in), 32'(pin_in));
  endtask

  task automatic tick(logic m, logic d);
    tms = m; tdi = d;
    @(posedge tck);
    model_rise();
    @(negedge tck);
    #1;
    compare_ports();
    seen_tdo = tdo;
  endtask

  task automatic shift_ir(logic [1:0] code, output logic [1:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 2; i++) begin
      cap[i] = seen_tdo;
      tick(i == 1, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(int n, logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = seen_tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] irc;
    logic [31:0] d;
    model_reset();
    repeat (2) @(negedge tck);
    #1;
    trst_n = 1'b1;
    check("R2 reset tdo_oe", 32'(tdo_oe), 32'd0);
    check("R7 reset pin_out", 32'(pin_out), 32'(core_out));
    tick(0, 0);

    // R4, R5: identify word read blind after reset
    shift_dr(32, 32'h0, d);
    check("R4 leading bit", 32'(d[0]), 32'd1);
    check("R5 id word", d, ID_EXP);

    // R3, R6: bypass
    shift_ir(C_BYP, irc);
    check("R3 ir capture", 32'(irc), 32'h1);
    shift_dr(6, 32'h2D, d);
    check("R6 bypass delay", d, {26'h0, 5'b01101, 1'b0});

    // R7, R8: sample, then preload 10110
    pin_in = 2'b10; core_out = 3'b011;
    shift_ir(C_SAMPLE, irc);
    shift_dr(NB, 32'h16, d);
    check("R7 sample capture", d, 32'({core_out, pin_in}));
    check("R7 pins undisturbed", 32'(pin_out), 32'(core_out));

    // R8, R9: drive-pins uses preloaded bits
    shift_ir(C_DRIVE, irc);
    check("R8 preload on pins", 32'(pin_out), 32'h5);
    core_out = 3'b100;
    tick(0, 0);
    check("R9 core ignored", 32'(pin_out), 32'h5);
    pin_in = 2'b01;
    shift_dr(NB, 32'h03, d);
    check("R9 drive capture", d, 32'({3'b100, 2'b01}));
    check("R10 update result", 32'(pin_out), 32'h0);

    // R1: scan broken by a pause: bits 1,0 then 1,1,1
    tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(1, 0);
    tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    tick(0, 1); tick(0, 1); tick(1, 1);
    tick(1, 0);
    check("R10 steady before update", 32'(pin_out), 32'h0);
    tick(0, 0);
    check("R1 pause resumed", 32'(pin_out), 32'h7);

    // R1, R4: five ones reach reset
    for (int i = 0; i < 5; i++) tick(1, 0);
    check("R1 tms reset pins", 32'(pin_out), 32'(core_out));
    tick(0, 0);
    shift_dr(32, 32'h0, d);
    check("R4 id after tms reset", d, ID_EXP);

    // R1: asynchronous reset out of drive-pins
    shift_ir(C_DRIVE, irc);
    check("R9 hold reloaded", 32'(pin_out), 32'h7);
    #2;
    trst_n = 1'b0;
    #1;
    model_reset();
    check("R1 async pins", 32'(pin_out), 32'(core_out));
    check("R1 async oe", 32'(tdo_oe), 32'd0);
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    tick(0, 0);
    shift_dr(32, 32'h0, d);
    check("R4 id after trst", d, ID_EXP);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule